// File: doc/BRIEF.md
# CFI Flash Query and Geometry Engine

This block runs the discovery handshake with one parallel NOR flash device that answers the common flash interface query. When `start` is pulsed, it places the device in query mode. It then confirms the three-character signature and reads the command-set code, the program and erase timeout exponents, the size exponent, and up to eight erase-block region descriptors. From these it builds a geometry table. Last, it returns the device to array-read mode with the exit command that suits the detected command set.

The engine drives a simple synchronous bus. Either the read strobe or the write strobe is held, with a fixed address, until the device answers with `fl_ready`. All command offsets are doubled on the byte address bus because the device is assumed to be 16 bits wide and wired in byte mode. The results are timeouts in clock cycles, which come from the `CLK_HZ` parameter, plus the chip size, the region count and one start/count/size entry per region. They are valid while `det_valid` is high.

Top module: `cfi_probe`

## Requirements
- R1: Each run starts with two bus writes: 0xF0 to byte address 0x000, then 0x98 to byte address 0x0AA (command offset 0x55 doubled). Every command offset X appears on `fl_addr` as byte address 2·X.
- R2: Command offsets 0x10, 0x11 and 0x12 must return 0x51, 0x52 and 0x59 ('Q', 'R', 'Y'). On the first mismatch the run ends: `done` pulses, `det_valid` stays 0, and no further bus access is made.
- R3: `cmdset_id` is little-endian, with the low byte from offset 0x13 and the high byte from offset 0x14.
- R4: `write_tmo` = 2^(b[0x1F]+b[0x23]) × (CLK_HZ/10^6). `erase_tmo` = 2^(b[0x21]+b[0x25]) × (CLK_HZ/10^3). Each saturates to all ones when the value does not fit in TMO_W bits.
- R5: `chip_size` = 2^b[0x27], saturating to all ones when the exponent is SIZE_W or more.
- R6: Region r takes two 16-bit little-endian fields at offset 0x2D+4r. The block count is the first field plus one. The block size is the second field × 256, and a second field of zero means 128 bytes.
- R7: Region 0 starts at offset 0. Region r+1 starts at the start of region r plus that region's block count × block size.
- R8: The region count is the byte at offset 0x2C. A value above MAX_RGN is clamped to MAX_RGN and sets `region_err`. A count of zero reads no descriptors.
- R9: Leaving query mode depends on the command set. Code 0x0002 writes 0xF0 and then 0xFF to byte address 0. Codes 0x0001 and 0x0003 write only 0xFF. Any other code writes nothing.
- R10: A strobe stays asserted, with a stable address, until `fl_ready` is seen. Read and write are never asserted together.
- R11: `start` is ignored while `busy` is high. An accepted `start` clears `det_valid`, `region_err` and every table entry, so regions beyond the count read as zero.
- R12: `done` is a one-cycle pulse at the end of every run. `det_valid` rises with `done` only when the run completes, and it is never high while `busy` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a query run (pulse) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| det_valid | output | 1 | Device found and table complete |
| cmdset_id | output | 16 | Command-set code |
| region_cnt | output | IDX_W | Regions in the table (clamped) |
| region_err | output | 1 | Reported region count exceeded MAX_RGN |
| chip_size | output | SIZE_W | Device size in bytes |
| write_tmo | output | TMO_W | Typical×worst program timeout in cycles |
| erase_tmo | output | TMO_W | Typical×worst erase timeout in cycles |
| rgn_start | output | MAX_RGN·OFS_W | Per-region start offsets, region r at bits r·OFS_W |
| rgn_blocks | output | MAX_RGN·17 | Per-region block counts |
| rgn_bsize | output | MAX_RGN·24 | Per-region block sizes in bytes |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_rd | output | 1 | Read strobe |
| fl_wr | output | 1 | Write strobe |
| fl_ready | input | 1 | Access complete |
| fl_rdata | input | 8 | Read data, valid with `fl_ready` |

## Verification
The bound checker watches bus discipline on every cycle: exclusive strobes, strobe and address held until ready, and only the three legal command bytes on writes. It also checks the clamp bound on the region count, the pairing of the error flag with that clamp, the single-cycle `done`, and that `det_valid` is never high during a run. Everything that depends on the device's answers can only be shown by the directed scenarios, which give the device model different contents and latencies. That covers the signature abort, the decoded geometry, the accumulated offsets, timeout scaling and saturation, and the exit write sequence for each command set.

// File: rtl/cfi_probe_pkg.sv
package cfi_probe_pkg;

  localparam int CNT_W = 17;  // 16-bit field plus one
  localparam int BSZ_W = 24;  // 16-bit field times 256

  typedef enum logic [2:0] {
    PH_IDLE, PH_RST, PH_QRY, PH_HDR, PH_RGN, PH_EXIT_F0, PH_EXIT_FF
  } phase_t;

  localparam logic [7:0]  CMD_RESET_A = 8'hF0;
  localparam logic [7:0]  CMD_RESET_B = 8'hFF;
  localparam logic [7:0]  CMD_QUERY   = 8'h98;
  localparam logic [7:0]  OFS_QUERY   = 8'h55;
  localparam logic [7:0]  OFS_RGN0    = 8'h2D;
  localparam logic [15:0] SET_A_STD   = 16'h0002;
  localparam logic [15:0] SET_B_EXT   = 16'h0001;
  localparam logic [15:0] SET_B_STD   = 16'h0003;

  // Header read order; the sequence index picks the command offset.
  function automatic logic [7:0] hdr_offset(input logic [3:0] step);
    case (step)
      4'd0:    return 8'h10;
      4'd1:    return 8'h11;
      4'd2:    return 8'h12;
      4'd3:    return 8'h13;
      4'd4:    return 8'h14;
      4'd5:    return 8'h1F;
      4'd6:    return 8'h21;
      4'd7:    return 8'h23;
      4'd8:    return 8'h25;
      4'd9:    return 8'h27;
      default: return 8'h2C;
    endcase
  endfunction

  function automatic logic [7:0] sig_byte(input logic [3:0] step);
    case (step)
      4'd0:    return 8'h51;
      4'd1:    return 8'h52;
      default: return 8'h59;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] decode_blocks(input logic [15:0] f);
    return {1'b0, f} + 17'd1;
  endfunction

  function automatic logic [BSZ_W-1:0] decode_bsize(input logic [15:0] f);
    return (f == 16'd0) ? 24'd128 : {f, 8'h00};
  endfunction

endpackage

// File: rtl/cfi_bus_port.sv
module cfi_bus_port #(
  parameter int ADDR_W = 24,
  parameter bit WIDE16 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_wr,
  input  logic [7:0]        go_off,
  input  logic [7:0]        go_data,
  output logic              ack,
  output logic [7:0]        ack_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_rd,
  output logic              fl_wr,
  input  logic              fl_ready,
  input  logic [7:0]        fl_rdata
);
  localparam int SH = WIDE16 ? 1 : 0;

  logic              rd_d, wr_d, ack_d;
  logic [ADDR_W-1:0] addr_d;
  logic [7:0]        wdata_d, data_d;

  always_comb begin
    rd_d    = fl_rd;
    wr_d    = fl_wr;
    addr_d  = fl_addr;
    wdata_d = fl_wdata;
    data_d  = ack_data;
    ack_d   = 1'b0;
    if ((fl_rd || fl_wr) && fl_ready) begin
      rd_d   = 1'b0;
      wr_d   = 1'b0;
      ack_d  = 1'b1;
      data_d = fl_rdata;
    end else if (go && !fl_rd && !fl_wr) begin
      rd_d    = !go_wr;
      wr_d    = go_wr;
      addr_d  = ADDR_W'(go_off) << SH;
      wdata_d = go_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_rd    <= 1'b0;
      fl_wr    <= 1'b0;
      ack      <= 1'b0;
      fl_addr  <= '0;
      fl_wdata <= '0;
      ack_data <= '0;
    end else begin
      fl_rd    <= rd_d;
      fl_wr    <= wr_d;
      ack      <= ack_d;
      fl_addr  <= addr_d;
      fl_wdata <= wdata_d;
      ack_data <= data_d;
    end
  end
endmodule

// File: rtl/cfi_tmo_scale.sv
module cfi_tmo_scale #(
  parameter int          TMO_W = 48,
  parameter int unsigned UNIT  = 125
) (
  input  logic [8:0]       expo,
  output logic [TMO_W-1:0] cycles
);
  logic [2*TMO_W-1:0] wide;

  always_comb begin
    wide = (2*TMO_W)'(UNIT) << expo;
    if ((expo >= 9'(TMO_W)) || (|wide[2*TMO_W-1:TMO_W]))
      cycles = '1;
    else
      cycles = wide[TMO_W-1:0];
  end
endmodule

// File: rtl/cfi_rgn_table.sv
module cfi_rgn_table
  import cfi_probe_pkg::*;
#(
  parameter int MAX_RGN = 8,
  parameter int OFS_W   = 40,
  parameter int IDX_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  logic [OFS_W-1:0]         w_start,
  input  logic [CNT_W-1:0]         w_blocks,
  input  logic [BSZ_W-1:0]         w_bsize,
  output logic [MAX_RGN*OFS_W-1:0] o_start,
  output logic [MAX_RGN*CNT_W-1:0] o_blocks,
  output logic [MAX_RGN*BSZ_W-1:0] o_bsize
);
  for (genvar g = 0; g < MAX_RGN; g++) begin : g_ent
    logic             hit;
    logic [OFS_W-1:0] st_q;
    logic [CNT_W-1:0] bl_q;
    logic [BSZ_W-1:0] bs_q;

    assign hit = we && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= '0;
        bl_q <= '0;
        bs_q <= '0;
      end else if (clr) begin
        st_q <= '0;
        bl_q <= '0;
        bs_q <= '0;
      end else if (hit) begin
        st_q <= w_start;
        bl_q <= w_blocks;
        bs_q <= w_bsize;
      end
    end

    assign o_start[g*OFS_W +: OFS_W]  = st_q;
    assign o_blocks[g*CNT_W +: CNT_W] = bl_q;
    assign o_bsize[g*BSZ_W +: BSZ_W]  = bs_q;
  end
endmodule

// File: rtl/cfi_probe.sv
module cfi_probe
  import cfi_probe_pkg::*;
#(
  parameter int          MAX_RGN = 8,
  parameter int          ADDR_W  = 24,
  parameter int          OFS_W   = 40,
  parameter int          SIZE_W  = 32,
  parameter int          TMO_W   = 48,
  parameter int unsigned CLK_HZ  = 125000000,
  localparam int         IDX_W   = $clog2(MAX_RGN + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic                     det_valid,
  output logic [15:0]              cmdset_id,
  output logic [IDX_W-1:0]         region_cnt,
  output logic                     region_err,
  output logic [SIZE_W-1:0]        chip_size,
  output logic [TMO_W-1:0]         write_tmo,
  output logic [TMO_W-1:0]         erase_tmo,
  output logic [MAX_RGN*OFS_W-1:0] rgn_start,
  output logic [MAX_RGN*17-1:0]    rgn_blocks,
  output logic [MAX_RGN*24-1:0]    rgn_bsize,
  output logic [ADDR_W-1:0]        fl_addr,
  output logic [7:0]               fl_wdata,
  output logic                     fl_rd,
  output logic                     fl_wr,
  input  logic                     fl_ready,
  input  logic [7:0]               fl_rdata
);
  localparam int unsigned US_UNIT = CLK_HZ / 1000000;
  localparam int unsigned MS_UNIT = CLK_HZ / 1000;

  phase_t           ph_q, ph_d;
  logic [3:0]       step_q, step_d;
  logic [IDX_W-1:0] ridx_q, ridx_d, rcnt_q, rcnt_d;
  logic [1:0]       rb_q, rb_d;
  logic             pend_q, pend_d, rerr_q, rerr_d;
  logic             valid_q, valid_d, done_q, done_d;
  logic [7:0]       raw0_q, raw0_d, raw1_q, raw1_d, raw2_q, raw2_d;
  logic [15:0]      id_q, id_d;
  logic [7:0]       wa_q, wa_d, ea_q, ea_d, szx_q, szx_d;
  logic [8:0]       ws_q, ws_d, es_q, es_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;

  logic             go, go_wr, ack;
  logic [7:0]       go_off, go_data, ack_data;
  logic             tbl_clr, tbl_we, to_exit, fin;
  logic [CNT_W-1:0] cur_blocks;
  logic [BSZ_W-1:0] cur_bsize;

  cfi_bus_port #(.ADDR_W(ADDR_W), .WIDE16(1'b1)) u_port (
    .clk(clk), .rst_n(rst_n), .go(go), .go_wr(go_wr), .go_off(go_off),
    .go_data(go_data), .ack(ack), .ack_data(ack_data), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_ready(fl_ready),
    .fl_rdata(fl_rdata)
  );

  cfi_rgn_table #(.MAX_RGN(MAX_RGN), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .clr(tbl_clr), .we(tbl_we), .idx(ridx_q),
    .w_start(ofs_q), .w_blocks(cur_blocks), .w_bsize(cur_bsize),
    .o_start(rgn_start), .o_blocks(rgn_blocks), .o_bsize(rgn_bsize)
  );

  cfi_tmo_scale #(.TMO_W(TMO_W), .UNIT(US_UNIT)) u_wtmo (.expo(ws_q), .cycles(write_tmo));
  cfi_tmo_scale #(.TMO_W(TMO_W), .UNIT(MS_UNIT)) u_etmo (.expo(es_q), .cycles(erase_tmo));

  assign cur_blocks = decode_blocks({raw1_q, raw0_q});
  assign cur_bsize  = decode_bsize({ack_data, raw2_q});

  // Access descriptor for the current phase.
  always_comb begin
    go      = (ph_q != PH_IDLE) && !pend_q;
    go_wr   = 1'b1;
    go_off  = 8'h00;
    go_data = CMD_RESET_A;
    case (ph_q)
      PH_QRY:     begin go_off = OFS_QUERY; go_data = CMD_QUERY; end
      PH_HDR:     begin go_wr = 1'b0; go_off = hdr_offset(step_q); end
      PH_RGN:     begin
        go_wr  = 1'b0;
        go_off = OFS_RGN0 + 8'({ridx_q, 2'b00}) + 8'(rb_q);
      end
      PH_EXIT_FF: go_data = CMD_RESET_B;
      default:    ;
    endcase
  end

  // Sequencer next state.
  always_comb begin
    ph_d = ph_q;  step_d = step_q;  ridx_d = ridx_q;  rcnt_d = rcnt_q;
    rb_d = rb_q;  pend_d = pend_q;  rerr_d = rerr_q;  valid_d = valid_q;
    raw0_d = raw0_q;  raw1_d = raw1_q;  raw2_d = raw2_q;  id_d = id_q;
    wa_d = wa_q;  ea_d = ea_q;  ws_d = ws_q;  es_d = es_q;  szx_d = szx_q;
    ofs_d = ofs_q;
    done_d = 1'b0;  tbl_clr = 1'b0;  tbl_we = 1'b0;
    to_exit = 1'b0;  fin = 1'b0;
    if (go) pend_d = 1'b1;
    if (ph_q == PH_IDLE) begin
      if (start) begin
        ph_d = PH_RST;  valid_d = 1'b0;  rerr_d = 1'b0;  rcnt_d = '0;
        ridx_d = '0;  step_d = '0;  rb_d = '0;  ofs_d = '0;  tbl_clr = 1'b1;
      end
    end else if (ack) begin
      pend_d = 1'b0;
      case (ph_q)
        PH_RST: ph_d = PH_QRY;
        PH_QRY: ph_d = PH_HDR;
        PH_HDR: begin
          step_d = step_q + 4'd1;
          case (step_q)
            4'd0, 4'd1, 4'd2:
              if (ack_data != sig_byte(step_q)) begin
                ph_d = PH_IDLE;  done_d = 1'b1;
              end
            4'd3: id_d[7:0]  = ack_data;
            4'd4: id_d[15:8] = ack_data;
            4'd5: wa_d = ack_data;
            4'd6: ea_d = ack_data;
            4'd7: ws_d = {1'b0, wa_q} + {1'b0, ack_data};
            4'd8: es_d = {1'b0, ea_q} + {1'b0, ack_data};
            4'd9: szx_d = ack_data;
            default: begin
              if (ack_data > 8'(MAX_RGN)) begin
                rcnt_d = IDX_W'(MAX_RGN);  rerr_d = 1'b1;
              end else begin
                rcnt_d = IDX_W'(ack_data);
              end
              if (ack_data == 8'd0) to_exit = 1'b1;
              else begin ph_d = PH_RGN;  ridx_d = '0;  rb_d = '0; end
            end
          endcase
        end
        PH_RGN: begin
          rb_d = rb_q + 2'd1;
          case (rb_q)
            2'd0: raw0_d = ack_data;
            2'd1: raw1_d = ack_data;
            2'd2: raw2_d = ack_data;
            default: begin
              tbl_we = 1'b1;
              ofs_d  = ofs_q + OFS_W'(cur_blocks * cur_bsize);
              ridx_d = ridx_q + IDX_W'(1);
              if (IDX_W'(ridx_q + IDX_W'(1)) == rcnt_q) to_exit = 1'b1;
            end
          endcase
        end
        PH_EXIT_F0: ph_d = PH_EXIT_FF;
        default:    fin = 1'b1;
      endcase
      if (to_exit) begin
        if (id_q == SET_A_STD)                           ph_d = PH_EXIT_F0;
        else if ((id_q == SET_B_STD) || (id_q == SET_B_EXT)) ph_d = PH_EXIT_FF;
        else fin = 1'b1;
      end
      if (fin) begin
        ph_d = PH_IDLE;  valid_d = 1'b1;  done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;  step_q <= '0;  ridx_q <= '0;  rcnt_q <= '0;
      rb_q <= '0;  pend_q <= 1'b0;  rerr_q <= 1'b0;  valid_q <= 1'b0;
      done_q <= 1'b0;  raw0_q <= '0;  raw1_q <= '0;  raw2_q <= '0;
      id_q <= '0;  wa_q <= '0;  ea_q <= '0;  ws_q <= '0;  es_q <= '0;
      szx_q <= '0;  ofs_q <= '0;
    end else begin
      ph_q <= ph_d;  step_q <= step_d;  ridx_q <= ridx_d;  rcnt_q <= rcnt_d;
      rb_q <= rb_d;  pend_q <= pend_d;  rerr_q <= rerr_d;  valid_q <= valid_d;
      done_q <= done_d;  raw0_q <= raw0_d;  raw1_q <= raw1_d;  raw2_q <= raw2_d;
      id_q <= id_d;  wa_q <= wa_d;  ea_q <= ea_d;  ws_q <= ws_d;  es_q <= es_d;
      szx_q <= szx_d;  ofs_q <= ofs_d;
    end
  end

  assign busy       = (ph_q != PH_IDLE);
  assign done       = done_q;
  assign det_valid  = valid_q;
  assign cmdset_id  = id_q;
  assign region_cnt = rcnt_q;
  assign region_err = rerr_q;
  assign chip_size  = (szx_q >= 8'(SIZE_W)) ? '1 : (SIZE_W'(1) << szx_q);
endmodule

// File: rtl/cfi_probe_chk.sv
module cfi_probe_chk #(
  parameter int MAX_RGN = 8,
  parameter int IDX_W   = 4,
  parameter int ADDR_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              det_valid,
  input logic [IDX_W-1:0]  region_cnt,
  input logic              region_err,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [7:0]        fl_wdata,
  input logic              fl_rd,
  input logic              fl_wr,
  input logic              fl_ready
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(fl_rd && fl_wr)); // R10
  AST_RD_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) (fl_rd && !fl_ready) |=> fl_rd); // R10
  AST_WR_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) (fl_wr && !fl_ready) |=> fl_wr); // R10
  AST_ADDR_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) ((fl_rd || fl_wr) && !fl_ready) |=> $stable(fl_addr)); // R10
  AST_WR_CODE:     assert property (@(posedge clk) disable iff (!rst_n) fl_wr |-> (fl_wdata == 8'hF0 || fl_wdata == 8'h98 || fl_wdata == 8'hFF)); // R9
  AST_CNT_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) region_cnt <= IDX_W'(MAX_RGN)); // R8
  AST_ERR_CLAMP:   assert property (@(posedge clk) disable iff (!rst_n) region_err |-> (region_cnt == IDX_W'(MAX_RGN))); // R8
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R12
  AST_VALID_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) det_valid |-> !busy); // R12
endmodule

bind cfi_probe cfi_probe_chk #(.MAX_RGN(MAX_RGN), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .det_valid(det_valid),
  .region_cnt(region_cnt), .region_err(region_err), .fl_addr(fl_addr),
  .fl_wdata(fl_wdata), .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_ready(fl_ready)
);

// File: tb/test_cfi_probe.sv
module test_cfi_probe;
  localparam int MAX_RGN = 8;
  localparam int OFS_W   = 40;
  localparam int TMO_W   = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, det_valid, region_err, fl_rd, fl_wr;
  logic fl_ready = 1'b0;
  logic [7:0] fl_rdata = 8'h00;
  logic [7:0] fl_wdata;
  logic [15:0] cmdset_id;
  logic [3:0] region_cnt;
  logic [31:0] chip_size;
  logic [TMO_W-1:0] write_tmo, erase_tmo;
  logic [MAX_RGN*OFS_W-1:0] rgn_start;
  logic [MAX_RGN*17-1:0] rgn_blocks;
  logic [MAX_RGN*24-1:0] rgn_bsize;
  logic [23:0] fl_addr;

  always #4 clk = ~clk;  // 125 MHz

  cfi_probe i_cfi_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .det_valid(det_valid), .cmdset_id(cmdset_id), .region_cnt(region_cnt),
    .region_err(region_err), .chip_size(chip_size), .write_tmo(write_tmo),
    .erase_tmo(erase_tmo), .rgn_start(rgn_start), .rgn_blocks(rgn_blocks),
    .rgn_bsize(rgn_bsize), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_ready(fl_ready), .fl_rdata(fl_rdata)
  );

  // Flash device model with programmable latency and access log.
  logic [7:0]  mem [0:255];
  logic [23:0] wl_addr [0:15];
  logic [7:0]  wl_data [0:15];
  int wn = 0, rn = 0, lat = 1, wcnt = 0;
  int errors = 0, checks = 0, cyc = 0;

  always @(posedge clk) begin
    fl_ready <= 1'b0;
    if ((fl_rd || fl_wr) && !fl_ready) begin
      if (wcnt >= lat) begin
        fl_ready <= 1'b1;
        wcnt = 0;
        if (fl_rd) begin fl_rdata <= mem[fl_addr[8:1]]; rn = rn + 1; end
        if (fl_wr && wn < 16) begin wl_addr[wn] = fl_addr; wl_data[wn] = fl_wdata; wn = wn + 1; end
      end else wcnt = wcnt + 1;
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
      report();
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] exp_tmo(input longint unsigned unit, input int s);
    logic [127:0] w;
    if (s >= TMO_W) return {16'h0, {TMO_W{1'b1}}};
    w = 128'(unit) << s;
    if (w[127:TMO_W] != '0) return {16'h0, {TMO_W{1'b1}}};
    return w[63:0];
  endfunction

  task automatic load(input logic [15:0] id, input logic [7:0] wa, wb, ea, eb, sz, cnt,
                      input logic [7:0] third);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h10] = 8'h51; mem[8'h11] = 8'h52; mem[8'h12] = third;
    mem[8'h13] = id[7:0]; mem[8'h14] = id[15:8];
    mem[8'h1F] = wa; mem[8'h23] = wb; mem[8'h21] = ea; mem[8'h25] = eb;
    mem[8'h27] = sz; mem[8'h2C] = cnt;
  endtask

  task automatic set_rgn(input int r, input logic [15:0] cf, input logic [15:0] sf);
    mem[8'(8'h2D + 4*r)] = cf[7:0]; mem[8'(8'h2D + 4*r + 1)] = cf[15:8];
    mem[8'(8'h2D + 4*r + 2)] = sf[7:0]; mem[8'(8'h2D + 4*r + 3)] = sf[15:8];
  endtask

  task automatic kick();
    wn = 0; rn = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk("R12 done seen", {63'd0, done}, 64'd1);
  endtask

  task automatic chk_entry(input string tag, input int r, input logic [63:0] st, bl, bs);
    chk({tag, " start"}, 64'(rgn_start[r*OFS_W +: OFS_W]), st);
    chk({tag, " blocks"}, 64'(rgn_blocks[r*17 +: 17]), bl);
    chk({tag, " bsize"}, 64'(rgn_bsize[r*24 +: 24]), bs);
  endtask

  task automatic t_reset();
    chk("R12 reset busy", {63'd0, busy}, 0);
    chk("R12 reset valid", {63'd0, det_valid}, 0);
    chk("R10 reset strobes", {62'd0, fl_rd, fl_wr}, 0);
  endtask

  task automatic t_std_a();
    lat = 1;
    load(16'h0002, 8'd4, 8'd5, 8'd9, 8'd2, 8'h16, 8'd2, 8'h59);
    set_rgn(0, 16'h0007, 16'h0020);
    set_rgn(1, 16'h003E, 16'h0100);
    kick();
    wait_done();
    chk("R12 valid on done", {63'd0, det_valid}, 1);
    chk("R1 write count", 64'(wn), 4);
    chk("R1 reset addr", 64'(wl_addr[0]), 0);
    chk("R1 reset data", 64'(wl_data[0]), 64'hF0);
    chk("R1 query addr", 64'(wl_addr[1]), 64'hAA);
    chk("R1 query data", 64'(wl_data[1]), 64'h98);
    chk("R9 exit first", {wl_addr[2], wl_data[2]}, 64'h0000F0);
    chk("R9 exit second", {wl_addr[3], wl_data[3]}, 64'h0000FF);
    chk("R3 id", 64'(cmdset_id), 64'h0002);
    chk("R4 write tmo", 64'(write_tmo), exp_tmo(125, 9));
    chk("R4 erase tmo", 64'(erase_tmo), exp_tmo(125000, 11));
    chk("R5 size", 64'(chip_size), 64'd4194304);
    chk("R8 count", 64'(region_cnt), 2);
    chk("R8 no err", {63'd0, region_err}, 0);
    chk_entry("R6 R7 rgn0", 0, 0, 8, 8192);
    chk_entry("R6 R7 rgn1", 1, 65536, 63, 65536);
    chk_entry("R11 unused rgn2", 2, 0, 0, 0);
    chk("R8 read count", 64'(rn), 19);
    @(negedge clk);
    chk("R12 done one cycle", {63'd0, done}, 0);
  endtask

  task automatic t_std_b_busy();
    lat = 3;
    load(16'h0003, 8'd0, 8'd0, 8'd0, 8'd0, 8'h10, 8'd1, 8'h59);
    set_rgn(0, 16'h00FF, 16'h0000);
    kick();
    repeat (6) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    chk("R11 restart ignored writes", 64'(wn), 3);
    chk("R11 restart ignored reads", 64'(rn), 15);
    chk("R9 single exit", {wl_addr[2], wl_data[2]}, 64'h0000FF);
    chk("R3 id b", 64'(cmdset_id), 64'h0003);
    chk_entry("R6 zero size", 0, 0, 256, 128);
    chk("R4 write tmo min", 64'(write_tmo), 125);
    chk("R4 erase tmo min", 64'(erase_tmo), 125000);
    chk("R5 size b", 64'(chip_size), 65536);
    chk_entry("R11 cleared rgn1", 1, 0, 0, 0);
  endtask

  task automatic t_clamp();
    logic [63:0] st = 0;
    lat = 0;
    load(16'h0001, 8'd30, 8'd20, 8'd3, 8'd4, 8'h20, 8'd12, 8'h59);
    for (int r = 0; r < 12; r++) set_rgn(r, 16'(r), 16'(r + 1));
    kick();
    wait_done();
    chk("R8 clamped", 64'(region_cnt), 8);
    chk("R8 err flag", {63'd0, region_err}, 1);
    chk("R8 reads", 64'(rn), 43);
    chk("R9 b-ext exit", {wl_addr[2], wl_data[2]}, 64'h0000FF);
    chk("R9 b-ext count", 64'(wn), 3);
    chk("R4 write sat", 64'(write_tmo), exp_tmo(125, 50));
    chk("R4 erase tmo", 64'(erase_tmo), exp_tmo(125000, 7));
    chk("R5 size sat", 64'(chip_size), 64'hFFFFFFFF);
    for (int r = 0; r < 8; r++) begin
      chk_entry("R7 accumulated", r, st, r + 1, (r + 1) * 256);
      st = st + 64'((r + 1) * (r + 1) * 256);
    end
  endtask

  task automatic t_other_set();
    lat = 2;
    load(16'h0007, 8'd1, 8'd1, 8'd1, 8'd1, 8'h11, 8'd0, 8'h59);
    kick();
    wait_done();
    chk("R9 no exit writes", 64'(wn), 2);
    chk("R8 zero count reads", 64'(rn), 11);
    chk("R12 valid other", {63'd0, det_valid}, 1);
    chk("R11 err cleared", {63'd0, region_err}, 0);
  endtask

  task automatic t_bad_sig();
    lat = 1;
    load(16'h0002, 8'd1, 8'd1, 8'd1, 8'd1, 8'h11, 8'd2, 8'h5A);
    kick();
    wait_done();
    chk("R2 not valid", {63'd0, det_valid}, 0);
    chk("R2 reads stop", 64'(rn), 3);
    chk("R2 writes stop", 64'(wn), 2);
    repeat (5) @(negedge clk);
    chk("R2 idle after abort", {61'd0, busy, fl_rd, fl_wr}, 0);
    chk_entry("R11 table cleared", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_std_a();
    t_std_b_busy();
    t_clamp();
    t_other_set();
    t_bad_sig();
    report();
  end
endmodule